// File: doc/BRIEF.md
# Eight-Port Power-Sourcing Event Register Bank

This block holds the event and status registers of an eight-port power-sourcing controller. Each port owns a byte-wide event register. Single-cycle hardware pulses from detection, classification and current-sensing logic set bits in that register. A host read of the register clears it. A global mask byte selects which event types reach a shared active-low interrupt line.

The bank also produces a detect-enable signal for each port. A per-port hold bit decides what happens after an unmasked event. When the hold bit is clear, the port may try detection again. When the hold bit is set, detection stays frozen until the host writes that hold bit back to 0.

A global configuration register holds three settings:
- a shared-power-management enable;
- an ignore-class-overload setting, which forces every per-port overload threshold selector to the class 0 code;
- an alternative-B setting, which inserts a backoff window after an invalid-signature event.

The configuration register also has a self-clearing software reset bit. The host reaches all registers through a simple bus with address, read strobe, write strobe and byte data. Read data is combinational from the address.

Top module: `pse_evt_bank`

## Requirements
- R1: After reset the following hold. Every event register reads 0x00, the mask (address 0x41) reads 0x00, the hold register (address 0x42) reads 0x00, irq_no is 1, and det_en_o is all ones.
- R2: A 1 on evt_i[7n+k] sets bit k of port n's event register, which reads at address 0x07 + 8·n. The bit meanings are: 6 power denied, 5 valid signature, 4 invalid signature, 3 short circuit, 2 overload, 1 DC maintain-power-signature absent, 0 AC maintain-power-signature absent. Bit 7 always reads 0.
- R3: An event register is read-only. A read strobe at its address returns the current value and clears the register on that clock edge. A write to that address has no effect.
- R4: If an event pulse arrives in the same cycle as a clearing read of that port, the pulsed bits are set after the read.
- R5: irq_no is 0 whenever any port holds an event bit k for which mask bit k is 0, and is 1 otherwise. A mask bit of 1 blocks that event type from the interrupt, but the event is still recorded.
- R6: Bit n of the hold register (address 0x42) belongs to port n. When that bit is clear, an unmasked event leaves det_en_o[n] at 1, unless the R10 backoff applies.
- R7: When hold bit n is set and an unmasked event pulses on port n, det_en_o[n] is 0 from the next cycle on. It stays 0 until the host writes the hold register with bit n equal to 0. An event blocked by the mask does not freeze the port.
- R8: The configuration register at 0x40 reads as follows after reset: bit 3 = 1, bit 2 = ico_pin_i, bit 1 = altb_pin_i, and bit 0 and bits 7:4 = 0. spm_en_o follows bit 3.
- R9: While configuration bit 2 is 1, every ovl_cls_o slice is 0 (the class 0 code). While it is 0, each slice equals the matching cls_i slice.
- R10: While configuration bit 1 is 1, an invalid-signature event (bit 4) on port n drives det_en_o[n] to 0 for BACKOFF_CYC cycles, starting the cycle after the pulse. While bit 1 is 0, an invalid-signature event causes no backoff.
- R11: Writing 1 to configuration bit 0 returns every register to its R1 and R8 default. Bit 0 reads 0 again once the reset has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe; clears an addressed event register |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| evt_i | input | 56 | Event pulses, 7 per port, port n at [7n+6:7n] |
| cls_i | input | 24 | Per-port class code, 3 bits per port |
| ico_pin_i | input | 1 | Reset value of ignore-class-overload |
| altb_pin_i | input | 1 | Reset value of alternative-B mode |
| irq_no | output | 1 | Active-low interrupt |
| det_en_o | output | 8 | Per-port detection permit |
| ovl_cls_o | output | 24 | Per-port overload threshold class code |
| spm_en_o | output | 1 | Shared power management enable |

## Verification
The critical coincidence is a host read clearing an event register in the same cycle that a hardware pulse sets one of its bits. The bench first records one event on a port. It then drives the clearing read together with a pulse of a different bit. The read must return only the earlier bit, and a second read must return only the bit pulsed during the first read. A second coincidence pairs a hold-register write with the freeze logic. Here the bench checks that a masked event leaves the port enabled while an unmasked one freezes it.

// File: rtl/pse_evt_pkg.sv
package pse_evt_pkg;
  localparam int EVT_W = 7;

  localparam int B_AC_MPS  = 0;
  localparam int B_DC_MPS  = 1;
  localparam int B_OVL     = 2;
  localparam int B_SHORT   = 3;
  localparam int B_INV_SIG = 4;
  localparam int B_VLD_SIG = 5;
  localparam int B_PWR_DEN = 6;

  localparam int C_SRST = 0;
  localparam int C_ALTB = 1;
  localparam int C_ICO  = 2;
  localparam int C_SPM  = 3;
endpackage

// File: rtl/pse_evt_glb.sv
module pse_evt_glb
  import pse_evt_pkg::*;
#(
  parameter int N_PORTS   = 8,
  parameter int DW        = 8,
  parameter int AW        = 8,
  parameter logic [AW-1:0] ADDR_CFG  = 8'h40,
  parameter logic [AW-1:0] ADDR_MASK = 8'h41,
  parameter logic [AW-1:0] ADDR_HOLD = 8'h42
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               ico_pin_i,
  input  logic               altb_pin_i,
  output logic [DW-1:0]      rdata_o,
  output logic [EVT_W-1:0]   mask_o,
  output logic [N_PORTS-1:0] hold_o,
  output logic [N_PORTS-1:0] hold_clr_o,
  output logic               srst_o,
  output logic               ico_o,
  output logic               altb_o,
  output logic               spm_o
);
  logic              spm_q, ico_q, altb_q, srst_q, init_q;
  logic [DW-1:0]     mask_q;
  logic [N_PORTS-1:0] hold_q;
  logic wr_cfg, wr_mask, wr_hold;

  assign wr_cfg  = wr_i && (addr_i == ADDR_CFG);
  assign wr_mask = wr_i && (addr_i == ADDR_MASK);
  assign wr_hold = wr_i && (addr_i == ADDR_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spm_q  <= 1'b1;
      ico_q  <= 1'b0;
      altb_q <= 1'b0;
      srst_q <= 1'b0;
      init_q <= 1'b0;
      mask_q <= '0;
      hold_q <= '0;
    end else if (srst_q) begin
      spm_q  <= 1'b1;
      ico_q  <= 1'b0;
      altb_q <= 1'b0;
      srst_q <= 1'b0;
      init_q <= 1'b0;
      mask_q <= '0;
      hold_q <= '0;
    end else begin
      // strap pins load on the first cycle after any reset
      if (!init_q) begin
        init_q <= 1'b1;
        ico_q  <= ico_pin_i;
        altb_q <= altb_pin_i;
      end else if (wr_cfg) begin
        spm_q  <= wdata_i[C_SPM];
        ico_q  <= wdata_i[C_ICO];
        altb_q <= wdata_i[C_ALTB];
        srst_q <= wdata_i[C_SRST];
      end
      if (wr_mask) mask_q <= wdata_i;
      if (wr_hold) hold_q <= wdata_i[N_PORTS-1:0];
    end
  end

  assign hold_clr_o = wr_hold ? ~wdata_i[N_PORTS-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CFG) begin
      rdata_o[C_SPM]  = spm_q;
      rdata_o[C_ICO]  = ico_q;
      rdata_o[C_ALTB] = altb_q;
      rdata_o[C_SRST] = srst_q;
    end else if (addr_i == ADDR_MASK) begin
      rdata_o = {1'b0, mask_q[DW-2:0]} | {mask_q[DW-1], {(DW-1){1'b0}}};
    end else if (addr_i == ADDR_HOLD) begin
      rdata_o[N_PORTS-1:0] = hold_q;
    end
  end

  assign mask_o = mask_q[EVT_W-1:0];
  assign hold_o = hold_q;
  assign srst_o = srst_q;
  assign ico_o  = ico_q;
  assign altb_o = altb_q;
  assign spm_o  = spm_q;
endmodule

// File: rtl/pse_evt_port.sv
module pse_evt_port
  import pse_evt_pkg::*;
#(
  parameter int BACKOFF_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] mask_i,
  input  logic             hold_i,
  input  logic             hold_clr_i,
  input  logic             rd_clr_i,
  input  logic             altb_i,
  output logic [EVT_W-1:0] evq_o,
  output logic             pend_o,
  output logic             det_en_o
);
  localparam int CNT_W = $clog2(BACKOFF_CYC + 1);

  logic [EVT_W-1:0] evq_q;
  logic             frz_q;
  logic [CNT_W-1:0] bo_q;
  logic             unmasked;

  assign unmasked = |(evt_i & ~mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evq_q <= '0;
      frz_q <= 1'b0;
      bo_q  <= '0;
    end else if (srst_i) begin
      evq_q <= '0;
      frz_q <= 1'b0;
      bo_q  <= '0;
    end else begin
      // a pulse coincident with the clearing read survives
      evq_q <= (rd_clr_i ? '0 : evq_q) | evt_i;
      if (hold_i && unmasked) frz_q <= 1'b1;
      else if (hold_clr_i)    frz_q <= 1'b0;
      if (altb_i && evt_i[B_INV_SIG]) bo_q <= CNT_W'(BACKOFF_CYC);
      else if (bo_q != '0)            bo_q <= bo_q - 1'b1;
    end
  end

  assign evq_o    = evq_q;
  assign pend_o   = |(evq_q & ~mask_i);
  assign det_en_o = !frz_q && (bo_q == '0);
endmodule

// File: rtl/pse_evt_bank.sv
module pse_evt_bank
  import pse_evt_pkg::*;
#(
  parameter int N_PORTS     = 8,
  parameter int DW          = 8,
  parameter int AW          = 8,
  parameter int CLS_W       = 3,
  parameter int BACKOFF_CYC = 16,
  parameter logic [AW-1:0] EVT_BASE   = 8'h07,
  parameter int            EVT_STRIDE = 8,
  parameter logic [AW-1:0] ADDR_CFG   = 8'h40,
  parameter logic [AW-1:0] ADDR_MASK  = 8'h41,
  parameter logic [AW-1:0] ADDR_HOLD  = 8'h42
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [AW-1:0]            addr_i,
  input  logic                     rd_i,
  input  logic                     wr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  input  logic [N_PORTS*EVT_W-1:0] evt_i,
  input  logic [N_PORTS*CLS_W-1:0] cls_i,
  input  logic                     ico_pin_i,
  input  logic                     altb_pin_i,
  output logic                     irq_no,
  output logic [N_PORTS-1:0]       det_en_o,
  output logic [N_PORTS*CLS_W-1:0] ovl_cls_o,
  output logic                     spm_en_o
);
  logic [N_PORTS*EVT_W-1:0] evq_all;
  logic [N_PORTS-1:0]       pend, port_sel, hold_q, hold_clr;
  logic [EVT_W-1:0]         mask_q;
  logic [DW-1:0]            glb_rdata;
  logic                     srst_q, ico_q, altb_q;

  pse_evt_glb #(
    .N_PORTS(N_PORTS), .DW(DW), .AW(AW),
    .ADDR_CFG(ADDR_CFG), .ADDR_MASK(ADDR_MASK), .ADDR_HOLD(ADDR_HOLD)
  ) u_glb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .ico_pin_i  (ico_pin_i),
    .altb_pin_i (altb_pin_i),
    .rdata_o    (glb_rdata),
    .mask_o     (mask_q),
    .hold_o     (hold_q),
    .hold_clr_o (hold_clr),
    .srst_o     (srst_q),
    .ico_o      (ico_q),
    .altb_o     (altb_q),
    .spm_o      (spm_en_o)
  );

  for (genvar n = 0; n < N_PORTS; n++) begin : g_port
    assign port_sel[n] = (addr_i == AW'(int'(EVT_BASE) + EVT_STRIDE * n));

    pse_evt_port #(.BACKOFF_CYC(BACKOFF_CYC)) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .srst_i     (srst_q),
      .evt_i      (evt_i[n*EVT_W +: EVT_W]),
      .mask_i     (mask_q),
      .hold_i     (hold_q[n]),
      .hold_clr_i (hold_clr[n]),
      .rd_clr_i   (rd_i && port_sel[n]),
      .altb_i     (altb_q),
      .evq_o      (evq_all[n*EVT_W +: EVT_W]),
      .pend_o     (pend[n]),
      .det_en_o   (det_en_o[n])
    );

    assign ovl_cls_o[n*CLS_W +: CLS_W] = ico_q ? '0 : cls_i[n*CLS_W +: CLS_W];
  end

  always_comb begin
    rdata_o = glb_rdata;
    for (int n = 0; n < N_PORTS; n++) begin
      if (port_sel[n]) rdata_o = {{(DW-EVT_W){1'b0}}, evq_all[n*EVT_W +: EVT_W]};
    end
  end

  assign irq_no = ~|pend;
endmodule

// File: rtl/pse_evt_bank_chk.sv
module pse_evt_bank_chk
  import pse_evt_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int AW      = 8,
  parameter int CLS_W   = 3,
  parameter logic [AW-1:0] EVT_BASE   = 8'h07,
  parameter int            EVT_STRIDE = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [AW-1:0]            addr_i,
  input logic                     rd_i,
  input logic [N_PORTS*EVT_W-1:0] evt_i,
  input logic [N_PORTS*EVT_W-1:0] evq,
  input logic [EVT_W-1:0]         mask_q,
  input logic [N_PORTS-1:0]       hold_q,
  input logic                     srst_q,
  input logic                     ico_q,
  input logic                     irq_no,
  input logic [N_PORTS-1:0]       det_en_o,
  input logic [N_PORTS*CLS_W-1:0] ovl_cls_o
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
    // R2 and R4: pulsed bits are set after the edge, read or not
    p_evt_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!srst_q && (evt_i[p*EVT_W +: EVT_W] != '0)) |=>
      ((evq[p*EVT_W +: EVT_W] & $past(evt_i[p*EVT_W +: EVT_W])) == $past(evt_i[p*EVT_W +: EVT_W])));

    p_rd_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && (addr_i == AW'(int'(EVT_BASE) + EVT_STRIDE * p)) &&
       (evt_i[p*EVT_W +: EVT_W] == '0) && !srst_q) |=> (evq[p*EVT_W +: EVT_W] == '0));

    p_irq_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((evq[p*EVT_W +: EVT_W] & ~mask_q) != '0) |-> !irq_no);

    p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!srst_q && hold_q[p] && ((evt_i[p*EVT_W +: EVT_W] & ~mask_q) != '0)) |=> !det_en_o[p]);

    p_cls0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ico_q |-> (ovl_cls_o[p*CLS_W +: CLS_W] == '0));
  end

  p_soft_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (evq == '0 && hold_q == '0 && mask_q == '0 && !srst_q));
endmodule

bind pse_evt_bank pse_evt_bank_chk #(
  .N_PORTS(N_PORTS), .AW(AW), .CLS_W(CLS_W),
  .EVT_BASE(EVT_BASE), .EVT_STRIDE(EVT_STRIDE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .evt_i     (evt_i),
  .evq       (evq_all),
  .mask_q    (mask_q),
  .hold_q    (hold_q),
  .srst_q    (srst_q),
  .ico_q     (ico_q),
  .irq_no    (irq_no),
  .det_en_o  (det_en_o),
  .ovl_cls_o (ovl_cls_o)
);

// File: tb/pse_evt_bank_tb_top.sv
module pse_evt_bank_tb_top;
  localparam int NP = 8;
  localparam int EW = 7;
  localparam int CW = 3;
  localparam int BO = 16;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [7:0]      addr_i = '0;
  logic            rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]      wdata_i = '0;
  logic [7:0]      rdata_o;
  logic [NP*EW-1:0] evt_i = '0;
  logic [NP*CW-1:0] cls_i = '0;
  logic            ico_pin_i = 1'b1, altb_pin_i = 1'b0;
  logic            irq_no, spm_en_o;
  logic [NP-1:0]   det_en_o;
  logic [NP*CW-1:0] ovl_cls_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk_i = ~clk_i;

  pse_evt_bank #(.BACKOFF_CYC(BO)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i), .cls_i(cls_i),
    .ico_pin_i(ico_pin_i), .altb_pin_i(altb_pin_i), .irq_no(irq_no),
    .det_en_o(det_en_o), .ovl_cls_o(ovl_cls_o), .spm_en_o(spm_en_o)
  );

  function automatic logic [7:0] eaddr(int p);
    return 8'(8'h07 + 8 * p);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data
  always @(negedge clk_i) begin
    if (rd_i) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read act=%0h exp=none", rdata_o);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata_o !== e) begin
          n_bad++;
          $display("FAIL %s addr=%0h act=%0h exp=%0h", t, addr_i, rdata_o, e);
        end
      end
    end
  end

  task automatic rd(logic [7:0] a, logic [7:0] e, string t, logic [NP*EW-1:0] ev = '0);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk_i); #1;
    addr_i = a; rd_i = 1'b1; evt_i = ev;
    @(posedge clk_i); #1;
    rd_i = 1'b0; evt_i = '0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk_i); #1;
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic pulse(int p, logic [6:0] bits);
    @(posedge clk_i); #1;
    evt_i = '0;
    evt_i[p*EW +: EW] = bits;
    @(posedge clk_i); #1;
    evt_i = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int p = 0; p < NP; p++) cls_i[p*CW +: CW] = CW'(p % 7 + 1);
    #20 rst_ni = 1'b1;
    idle(3);

    // R1 reset state
    for (int p = 0; p < NP; p++) rd(eaddr(p), 8'h00, "R1 evt reg");
    rd(8'h41, 8'h00, "R1 mask");
    rd(8'h42, 8'h00, "R1 hold");
    chk("R1 irq_no", 32'(irq_no), 1);
    chk("R1 det_en", 32'(det_en_o), 32'hFF);

    // R8 configuration defaults, ico pin 1, altb pin 0
    rd(8'h40, 8'h0C, "R8 cfg");
    chk("R8 spm_en", 32'(spm_en_o), 1);

    // R9 class forced to 0
    chk("R9 ovl forced", 32'(ovl_cls_o), 0);
    wr(8'h40, 8'h08);
    chk("R9 ovl passthrough", 32'(ovl_cls_o), 32'(cls_i));

    // R2 bit placement and R5 interrupt
    pulse(3, 7'b1000001);
    chk("R5 irq on event", 32'(irq_no), 0);
    chk("R6 det_en hold clear", 32'(det_en_o), 32'hFF);
    rd(eaddr(3), 8'h41, "R2 port3 bits");
    rd(eaddr(3), 8'h00, "R3 cleared");
    chk("R5 irq released", 32'(irq_no), 1);
    pulse(7, 7'b0010000);
    rd(eaddr(7), 8'h10, "R2 port7 invalid sig");

    // R3 write ignored
    pulse(0, 7'b0001000);
    wr(eaddr(0), 8'hFF);
    rd(eaddr(0), 8'h08, "R3 write ignored");

    // R4 coincident pulse and read
    pulse(5, 7'b0100000);
    begin
      logic [NP*EW-1:0] ev = '0;
      ev[5*EW +: EW] = 7'b0000100;
      rd(eaddr(5), 8'h20, "R4 read returns old", ev);
    end
    rd(eaddr(5), 8'h04, "R4 coincident bit kept");
    rd(eaddr(5), 8'h00, "R4 then cleared");

    // R5 masking
    wr(8'h41, 8'h08);
    pulse(1, 7'b0001000);
    chk("R5 masked no irq", 32'(irq_no), 1);
    pulse(1, 7'b0000010);
    chk("R5 unmasked irq", 32'(irq_no), 0);
    rd(eaddr(1), 8'h0A, "R5 masked still recorded");
    chk("R5 irq after clear", 32'(irq_no), 1);
    wr(8'h41, 8'h00);

    // R6 / R7 hold
    wr(8'h42, 8'h04);
    pulse(2, 7'b0001000);
    chk("R7 frozen", 32'(det_en_o[2]), 0);
    pulse(6, 7'b0001000);
    chk("R6 other port free", 32'(det_en_o[6]), 1);
    rd(eaddr(2), 8'h08, "R7 evt");
    rd(eaddr(6), 8'h08, "R6 evt");
    idle(10);
    chk("R7 still frozen", 32'(det_en_o[2]), 0);
    wr(8'h42, 8'h04);
    chk("R7 hold rewrite 1 keeps freeze", 32'(det_en_o[2]), 0);
    wr(8'h42, 8'h00);
    chk("R7 released", 32'(det_en_o[2]), 1);
    wr(8'h41, 8'h08);
    wr(8'h42, 8'h04);
    pulse(2, 7'b0001000);
    chk("R7 masked no freeze", 32'(det_en_o[2]), 1);
    rd(eaddr(2), 8'h08, "R7 masked evt");
    wr(8'h42, 8'h00);
    wr(8'h41, 8'h00);

    // R10 backoff
    pulse(4, 7'b0010000);
    chk("R10 no backoff altb off", 32'(det_en_o[4]), 1);
    rd(eaddr(4), 8'h10, "R10 evt a");
    wr(8'h40, 8'h0A);
    rd(8'h40, 8'h0A, "R8 cfg write");
    pulse(4, 7'b0010000);
    chk("R10 backoff start", 32'(det_en_o[4]), 0);
    idle(BO - 2);
    chk("R10 backoff mid", 32'(det_en_o[4]), 0);
    idle(3);
    chk("R10 backoff over", 32'(det_en_o[4]), 1);
    rd(eaddr(4), 8'h10, "R10 evt b");

    // R11 soft reset
    altb_pin_i = 1'b1;
    wr(8'h41, 8'h55);
    wr(8'h42, 8'h03);
    pulse(0, 7'b0001000);
    chk("R11 frozen before", 32'(det_en_o[0]), 0);
    wr(8'h40, 8'h01);
    idle(4);
    rd(8'h40, 8'h0E, "R11 cfg default");
    rd(8'h41, 8'h00, "R11 mask default");
    rd(8'h42, 8'h00, "R11 hold default");
    rd(eaddr(0), 8'h00, "R11 evt cleared");
    chk("R11 det_en", 32'(det_en_o), 32'hFF);
    chk("R11 irq", 32'(irq_no), 1);

    idle(2);
    finish_run();
  end
endmodule